// File: doc/BRIEF.md
# Mode-Selectable Four-Master Bus Arbiter

This block decides which of four bus masters may drive a shared high-performance bus. Each master raises its own request line. A 2-bit mode input picks the decision policy at run time:

| Mode code | Policy |
|---|---|
| 00 | fixed priority |
| 01 | rotating token |
| 10 | pseudo-random |
| 11 | round robin with time slots sized by the burst code |

Only one grant line is high at any moment. When nobody holds the bus, master 0 owns it by default.

A controller walks a fixed path: idle, arbitration (where the mode is latched), policy decision (where the winner and the burst code are latched), master-number phase, and transfer phase. It then returns to idle. The transfer phase ends on any of three events: the slave reports completion on `xfer_done`, the granted master drops its request, or, in round-robin mode, its slot runs out. After that the master has to request again. The 4-bit master-number output names the current owner.

Top module: `modal_bus_arbiter`

## Requirements
- R1: While `rst_n` is low (sampled on the rising clock edge), and while the controller is idle, `grant` is 0001 (master 0 as default owner) and `master_id` is 0. With all requests low the controller stays idle.
- R2: Suppose the idle controller sees a nonzero `bus_req` at clock edge E0.
  - `mode` is sampled at E0+1.
  - The winner is chosen from `bus_req` and `burst` at E0+2.
  - `grant` and `master_id` take the winner's values after E0+2.
  - The transfer phase begins after E0+3.
  - A non-default master is granted only if it was requesting at the deciding edge.
- R3: Mode 00 is fixed priority: master 0 beats 1, 1 beats 2, and 2 beats 3.
- R4: Mode 01 uses a token held in a one-hot ring. The token sits at master 0 out of reset and moves to the next master (0,1,2,3,0...) on every clock edge. The winner is the first requester found searching upward from the token holder, wrapping around.
- R5: Mode 10 uses a 4-bit LFSR.
  - It is seeded with 0001 by reset and steps on every edge as next = {l[2:0], l[3]^l[2]}.
  - Master i's number is l rotated left by i bits.
  - The requester with the largest number wins, and ties go to the lowest index.
- R6: Mode 11 uses a round-robin pointer. The winner is the first requester after the master last granted in this mode, wrapping around. The pointer starts at master 3, so master 0 is served first.
- R7: In mode 11 the transfer phase lasts at most a slot of N cycles, after which the controller returns to idle.
  - Burst codes 010 and 011 give N=4.
  - Codes 100 and 101 give N=8.
  - Codes 110 and 111 give N=16.
  - Codes 000 and 001 give N=1.
- R8: `xfer_done` high during the transfer phase returns the controller to idle on the next edge, with `grant` 0001 and `master_id` 0.
- R9: If the granted master's request is low during the transfer phase, the controller returns to idle on the next edge.
- R10: After reset exactly one `grant` bit is high, and `master_id` is the index of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | 4 | Request line per master |
| mode | input | 2 | Policy select (00 fixed, 01 token, 10 random, 11 round robin) |
| burst | input | 3 | Burst-type code, sets the round-robin slot length |
| xfer_done | input | 1 | Slave's end-of-transfer indication |
| grant | output | 4 | One-hot grant, bit i for master i |
| master_id | output | 4 | Number of the current owner |

## Verification
- **Fixed priority** is driven with mixed request sets (1010, 1000, 1111). These distinguish a true priority order from a pick-any-requester behaviour.
- **Token mode** receives sparse and single requests at different cycle offsets. This shows that the winner follows the moving token rather than the index order.
- **Random mode** gets full and partial request sets, compared against an independent LFSR model. This separates the largest-number rule and the lowest-index tie break from plain priority.
- **Round robin** sees repeated full requests, which show the pointer advancing. Slot runs under 4-beat and single-beat codes tell a slot cutoff apart from a done-driven or request-drop exit.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NM   = 4;             // masters
    localparam int IDW  = 4;             // master-number width
    localparam int LW   = 4;             // LFSR width
    localparam int CNTW = 5;             // slot counter width
    localparam int SELW = $clog2(NM);

    localparam logic [NM-1:0] DEF_GRANT = NM'(1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_POL,
        ST_MNUM,
        ST_XFER
    } arb_state_e;

    typedef enum logic [1:0] {
        POL_FIXED = 2'b00,
        POL_TOKEN = 2'b01,
        POL_RAND  = 2'b10,
        POL_RR    = 2'b11
    } pol_e;

    typedef struct packed {
        logic [NM-1:0]  onehot;
        logic [IDW-1:0] idx;
    } pick_t;

    function automatic logic [CNTW-1:0] slot_len(input logic [2:0] code);
        case (code[2:1])
            2'b01:   return CNTW'(4);
            2'b10:   return CNTW'(8);
            2'b11:   return CNTW'(16);
            default: return CNTW'(1);
        endcase
    endfunction

    function automatic logic [LW-1:0] rotl(input logic [LW-1:0] v, input int sh);
        logic [2*LW-1:0] d;
        d = {v, v} << sh;
        return d[2*LW-1:LW];
    endfunction

    function automatic logic [SELW-1:0] oh2idx(input logic [NM-1:0] v);
        logic [SELW-1:0] r;
        r = '0;
        for (int k = 0; k < NM; k++)
            if (v[k]) r = r | SELW'(k);
        return r;
    endfunction

endpackage

// File: rtl/arb_lfsr.sv
module arb_lfsr #(
    parameter int           W    = 4,
    parameter logic [W-1:0] TAPS = 4'b1100,
    parameter logic [W-1:0] SEED = 4'b0001
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n) value <= SEED;
        else        value <= {value[W-2:0], ^(value & TAPS)};
    end
endmodule

// File: rtl/arb_ring.sv
module arb_ring #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [N-1:0] token
);
    always_ff @(posedge clk) begin
        if (!rst_n) token <= N'(1);
        else        token <= {token[N-2:0], token[N-1]};
    end
endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
(
    input  pol_e            pol,
    input  logic [NM-1:0]   req,
    input  logic [SELW-1:0] tok_idx,
    input  logic [LW-1:0]   rnd,
    input  logic [SELW-1:0] rr_last,
    output pick_t           pick
);
    logic [SELW-1:0] start;
    logic [SELW-1:0] circ_win;
    logic [SELW-1:0] rnd_win;
    logic            circ_hit;
    logic            rnd_hit;
    logic [LW-1:0]   best;
    logic [SELW-1:0] cand;
    logic [SELW-1:0] win;

    always_comb begin
        case (pol)
            POL_TOKEN: start = tok_idx;
            POL_RR:    start = rr_last + SELW'(1);
            default:   start = '0;
        endcase
    end

    // first requester at or after start, wrapping
    always_comb begin
        circ_hit = 1'b0;
        circ_win = '0;
        cand     = '0;
        for (int k = 0; k < NM; k++) begin
            cand = start + SELW'(k);
            if (!circ_hit && req[cand]) begin
                circ_hit = 1'b1;
                circ_win = cand;
            end
        end
    end

    // largest rotated LFSR value, strict compare keeps lowest index on ties
    always_comb begin
        rnd_hit = 1'b0;
        rnd_win = '0;
        best    = '0;
        for (int i = 0; i < NM; i++) begin
            if (req[i] && (!rnd_hit || rotl(rnd, i) > best)) begin
                rnd_hit = 1'b1;
                rnd_win = SELW'(i);
                best    = rotl(rnd, i);
            end
        end
    end

    always_comb begin
        if (pol == POL_RAND) win = rnd_hit  ? rnd_win  : '0;
        else                 win = circ_hit ? circ_win : '0;
        pick.onehot = NM'(1) << win;
        pick.idx    = IDW'(win);
    end
endmodule

// File: rtl/modal_bus_arbiter.sv
module modal_bus_arbiter
    import arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_req,
    input  logic [1:0]  mode,
    input  logic [2:0]  burst,
    input  logic        xfer_done,
    output logic [3:0]  grant,
    output logic [3:0]  master_id
);
    arb_state_e      state_q;
    pol_e            pol_q;
    logic [NM-1:0]   grant_q;
    logic [IDW-1:0]  id_q;
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] slot_q;
    logic [SELW-1:0] rr_last_q;
    logic [NM-1:0]   token;
    logic [LW-1:0]   rnd;
    pick_t           pick;
    logic            xfer_end;

    arb_ring #(.N(NM)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .token (token)
    );

    arb_lfsr #(.W(LW), .TAPS(4'b1100), .SEED(4'b0001)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    arb_pick u_pick (
        .pol     (pol_q),
        .req     (bus_req),
        .tok_idx (oh2idx(token)),
        .rnd     (rnd),
        .rr_last (rr_last_q),
        .pick    (pick)
    );

    assign xfer_end = xfer_done
                   || ((bus_req & grant_q) == '0)
                   || (pol_q == POL_RR && cnt_q == slot_q - CNTW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pol_q     <= POL_FIXED;
            grant_q   <= DEF_GRANT;
            id_q      <= '0;
            cnt_q     <= '0;
            slot_q    <= CNTW'(1);
            rr_last_q <= SELW'(NM - 1);
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (|bus_req) state_q <= ST_ARB;
                end
                ST_ARB: begin
                    pol_q   <= pol_e'(mode);
                    state_q <= ST_POL;
                end
                ST_POL: begin
                    grant_q <= pick.onehot;
                    id_q    <= pick.idx;
                    slot_q  <= slot_len(burst);
                    if (pol_q == POL_RR) rr_last_q <= pick.idx[SELW-1:0];
                    state_q <= ST_MNUM;
                end
                ST_MNUM: begin
                    cnt_q   <= '0;
                    state_q <= ST_XFER;
                end
                ST_XFER: begin
                    cnt_q <= cnt_q + CNTW'(1);
                    if (xfer_end) begin
                        grant_q <= DEF_GRANT;
                        id_q    <= '0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign grant     = grant_q;
    assign master_id = id_q;
endmodule

// File: rtl/modal_bus_arbiter_chk.sv
module modal_bus_arbiter_chk
    import arb_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input arb_state_e  state,
    input pol_e        pol,
    input logic [3:0]  bus_req,
    input logic        xfer_done,
    input logic [3:0]  grant,
    input logic [3:0]  master_id
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && bus_req == '0) |=> (state == ST_IDLE && grant == DEF_GRANT)); // R1
    AST_ARB_TO_POL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARB) |=> (state == ST_POL)); // R2
    AST_POL_TO_MNUM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POL) |=> (state == ST_MNUM)); // R2
    AST_MNUM_TO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MNUM) |=> (state == ST_XFER)); // R2
    generate
        for (genvar g = 1; g < NM; g++) begin : g_req
            AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(grant[g]) |-> $past(bus_req[g])); // R2
        end
    endgenerate
    AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POL && pol == POL_FIXED && bus_req[0]) |=> (grant == 4'b0001)); // R3
    AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && xfer_done) |=> (state == ST_IDLE && grant == DEF_GRANT && master_id == '0)); // R8
    AST_DROP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && (bus_req & grant) == '0) |=> (state == ST_IDLE)); // R9
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) == 1); // R10
    AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (master_id < 4'(NM)) && grant[master_id[SELW-1:0]]); // R10
endmodule

bind modal_bus_arbiter modal_bus_arbiter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .pol       (pol_q),
    .bus_req   (bus_req),
    .xfer_done (xfer_done),
    .grant     (grant),
    .master_id (master_id)
);

// File: tb/tb_modal_bus_arbiter.sv
module tb_modal_bus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] bus_req;
    logic [1:0] mode;
    logic [2:0] burst;
    logic       xfer_done;
    logic [3:0] grant;
    logic [3:0] master_id;

    int n_chk  = 0;
    int n_fail = 0;
    int rr_last_m = 3;

    logic [1:0] m_tok;
    logic [3:0] m_lfsr;

    always #4 clk = ~clk;

    modal_bus_arbiter dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .mode(mode),
        .burst(burst), .xfer_done(xfer_done), .grant(grant), .master_id(master_id)
    );

    // independent model of token position and LFSR (R4, R5)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tok  <= 2'd0;
            m_lfsr <= 4'b0001;
        end else begin
            m_tok  <= m_tok + 2'd1;
            m_lfsr <= {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
        end
    end

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_fixed(input logic [3:0] r);
        for (int i = 0; i < 4; i++) if (r[i]) return i;
        return 0;
    endfunction

    function automatic int exp_circ(input logic [3:0] r, input int from);
        for (int k = 0; k < 4; k++) if (r[(from + k) % 4]) return (from + k) % 4;
        return 0;
    endfunction

    function automatic int exp_rand(input logic [3:0] r, input logic [3:0] l);
        int w = -1;
        int b = -1;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] d;
            int v;
            d = {l, l} << i;
            v = int'(d[7:4]);
            if (r[i] && v > b) begin
                b = v;
                w = i;
            end
        end
        return (w < 0) ? 0 : w;
    endfunction

    // from idle at a negedge: drive request, walk to master-number phase, check grant
    task automatic acquire(input string tag, input logic [1:0] m, input logic [3:0] r,
                           input logic [2:0] b, output int expi);
        bus_req = r;
        mode    = m;
        burst   = b;
        step();  // arbitration
        step();  // policy decision
        case (m)
            2'b00: expi = exp_fixed(r);
            2'b01: expi = exp_circ(r, int'(m_tok));
            2'b10: expi = exp_rand(r, m_lfsr);
            default: expi = exp_circ(r, (rr_last_m + 1) % 4);
        endcase
        if (m == 2'b11) rr_last_m = expi;
        step();  // master-number phase
        check({tag, " grant"}, grant, 4'(1 << expi));
        check({tag, " master_id"}, master_id, 4'(expi));
    endtask

    // end the transfer with xfer_done, check the return to default (R8)
    task automatic finish_done(input string tag, input int expi);
        xfer_done = 1'b1;
        step();  // transfer phase
        check({tag, " R8 held in transfer"}, grant, 4'(1 << expi));
        step();  // idle
        check({tag, " R8 grant default"}, grant, 4'b0001);
        check({tag, " R8 id zero"}, master_id, 4'd0);
        xfer_done = 1'b0;
        bus_req   = 4'b0000;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        bus_req = '0; mode = '0; burst = '0; xfer_done = 1'b0;
        step(); step();
        check("R1 reset grant", grant, 4'b0001);
        check("R1 reset id", master_id, 4'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) step();
        check("R1 idle grant", grant, 4'b0001);
        check("R1 idle id", master_id, 4'd0);
    endtask

    task automatic t_fixed();
        int e;
        acquire("R3 fixed 1010", 2'b00, 4'b1010, 3'b000, e);
        check("R3 fixed 1010 winner", 4'(e), 4'd1);
        finish_done("R3a", e);
        acquire("R3 fixed 1000", 2'b00, 4'b1000, 3'b000, e);
        check("R3 fixed 1000 winner", 4'(e), 4'd3);
        finish_done("R3b", e);
        acquire("R3 fixed 1111", 2'b00, 4'b1111, 3'b000, e);
        check("R3 fixed 1111 winner", 4'(e), 4'd0);
        finish_done("R3c", e);
    endtask

    task automatic t_token();
        int e;
        acquire("R4 token 0101", 2'b01, 4'b0101, 3'b000, e);
        finish_done("R4a", e);
        step();
        acquire("R4 token 1001", 2'b01, 4'b1001, 3'b000, e);
        finish_done("R4b", e);
        acquire("R4 token 1110", 2'b01, 4'b1110, 3'b000, e);
        finish_done("R4c", e);
    endtask

    task automatic t_random();
        int e;
        acquire("R5 random 1111", 2'b10, 4'b1111, 3'b000, e);
        finish_done("R5a", e);
        acquire("R5 random 0110", 2'b10, 4'b0110, 3'b000, e);
        finish_done("R5b", e);
        step(); step();
        acquire("R5 random 1011", 2'b10, 4'b1011, 3'b000, e);
        finish_done("R5c", e);
    endtask

    task automatic t_rr();
        int e;
        acquire("R6 rr first", 2'b11, 4'b1111, 3'b110, e);
        check("R6 rr first winner", 4'(e), 4'd0);
        finish_done("R6a", e);
        acquire("R6 rr second", 2'b11, 4'b1111, 3'b110, e);
        check("R6 rr second winner", 4'(e), 4'd1);
        finish_done("R6b", e);
        acquire("R6 rr skip", 2'b11, 4'b1001, 3'b110, e);
        check("R6 rr skip winner", 4'(e), 4'd3);
        finish_done("R6c", e);
    endtask

    task automatic t_slot();
        int e;
        acquire("R7 slot4", 2'b11, 4'b0100, 3'b011, e);
        step();  // transfer cycle 1
        step(); step(); // cycles 2,3
        step();  // cycle 4
        check("R7 slot4 last cycle held", grant, 4'(1 << e));
        step();
        check("R7 slot4 expired", grant, 4'b0001);
        bus_req = 4'b0000;
        step();
        acquire("R7 slot1", 2'b11, 4'b0010, 3'b000, e);
        step();  // single transfer cycle
        check("R7 slot1 held", grant, 4'(1 << e));
        step();
        check("R7 slot1 expired", grant, 4'b0001);
        bus_req = 4'b0000;
        step();
    endtask

    task automatic t_drop();
        int e;
        acquire("R9 drop", 2'b00, 4'b0100, 3'b000, e);
        step();  // transfer phase
        check("R9 before drop", grant, 4'b0100);
        bus_req = 4'b0000;
        step();
        check("R9 grant default", grant, 4'b0001);
        check("R10 id after drop", master_id, 4'd0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fixed();
        t_token();
        t_random();
        t_rr();
        t_slot();
        t_drop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule